// File: doc/BRIEF.md
# MSI-X Capability Register Block

This block holds the MSI-X capability structure of a device's configuration space. It is configured at build time with the number of message vectors it offers, the index of the BAR that carries the vector table and pending-bit array, and the value of the next-capability pointer. At run time it takes the size of the device's own BAR. From that size it works out how large the BAR must become once a page-aligned MSI-X region is placed above the original contents. It then presents the table and pending-array offset registers that point into that region.

Software reaches the structure through a dword-addressed configuration port with byte enables. Reads return data one cycle after the request. Only two bits can be written: the MSI-X enable bit and the function-mask bit in the top byte of the message-control word. A write that covers that byte can leave MSI-X enabled. In that case the block emits a one-cycle pulse telling the legacy interrupt logic to drop its INTx line. If the function mask is also clear after the write, it emits a one-cycle rescan request asking the vector dispatcher to re-examine every pending vector.

An out-of-range vector count removes the capability, and so does a host BAR larger than 2 GiB. The capability then reads as zero and its bits cannot be written.

Top module: `msix_cap_block`

## Requirements
- R1: After reset, msix_enable, func_mask, intx_deassert, rescan_req and cfg_rvalid are all 0.
- R2: Dword 0 reads as: bits 7:0 capability ID 0x11, bits 15:8 the next pointer, bits 26:16 the vector count minus one, bits 29:27 zero, bit 30 the function mask, bit 31 the enable.
- R3: The reported BAR size is derived from the host BAR size as follows: a host size of 0 reports 0x1000; a size from 1 to 0xFFF reports 0x2000; a size from 0x1000 to 0x8000_0000 reports twice the host size; a size above 0x8000_0000 drops cap_present and reports the host size unchanged.
- R4: Let S be the host BAR size rounded to 0x1000 when it lies between 1 and 0xFFF, and left as it is otherwise. Dword 1 (table offset) reads as S ORed with the BAR index in bits 2:0. Dword 2 (pending-array offset) reads as S + 0x800 ORed with the BAR index.
- R5: A vector count outside 1..2048 drops cap_present. With cap_present low, every dword reads 0, writes leave msix_enable and func_mask at 0, and no pulse is emitted.
- R6: A write changes msix_enable (wdata bit 31) and func_mask (wdata bit 30) only when it targets dword 0 with byte enable 3 set. Every other bit, byte and dword is read-only.
- R7: A write covering the control byte that leaves the enable bit at 1 makes intx_deassert high for exactly the one cycle after the write. No other cycle pulses.
- R8: Such a write that also leaves the function mask at 0 makes rescan_req high for exactly the one cycle after the write. Writes that do not cover the control byte never pulse.
- R9: cfg_rdata and cfg_rvalid are valid in the cycle after cfg_rd. Dword index 3 reads 0.
- R10: Asserting reset while running clears msix_enable and func_mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_bar_size | input | 32 | Size in bytes of the device's original BAR |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_addr | input | 2 | Dword index within the capability |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, one cycle after cfg_rd |
| cfg_rvalid | output | 1 | Read data valid |
| cap_present | output | 1 | Capability is presented |
| bar_size | output | 33 | Enlarged BAR size in bytes |
| msix_enable | output | 1 | MSI-X enable bit |
| func_mask | output | 1 | Function-mask bit |
| intx_deassert | output | 1 | One-cycle request to drop legacy INTx |
| rescan_req | output | 1 | One-cycle request to re-examine pending vectors |

## Verification
The stored state is the enable and mask pair plus the two pulse registers. A wrong stored value shows on msix_enable or func_mask, and in bits 31:30 of dword 0, one cycle after the faulty write. A wrong pulse decision shows on intx_deassert or rescan_req in that same cycle. The derived offsets have no state, so a fault in the size arithmetic shows on bar_size at once and on the next dword read a cycle later. The bench therefore sweeps every prior state, byte-enable pattern and written value, and walks the host size across each boundary of the rounding rule.

// File: rtl/msix_cap_pkg.sv
package msix_cap_pkg;
  localparam logic [7:0]  CAP_ID       = 8'h11;
  localparam int          TSIZE_W      = 11;
  localparam int          MAX_VEC      = 1 << TSIZE_W;
  localparam int          PAGE_BYTES   = 4096;
  localparam int          PBA_OFS      = PAGE_BYTES / 2;
  localparam int          BIR_W        = 3;
  localparam logic [31:0] MAX_HOST_BAR = 32'h8000_0000;
  localparam int          CAP_DWORDS   = 3;
  localparam int          ADDR_W       = 2;
  localparam int          EN_BIT       = 31;
  localparam int          MASK_BIT     = 30;
endpackage

// File: rtl/msix_rst_sync.sv
module msix_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/msix_bar_calc.sv
module msix_bar_calc
  import msix_cap_pkg::*;
#(
  parameter int BAR_IDX = 0
) (
  input  logic [31:0] host_size,
  output logic        size_ok,
  output logic [32:0] new_size,
  output logic [31:0] table_ofs,
  output logic [31:0] pba_ofs
);
  localparam logic [31:0]      PAGE32 = 32'(PAGE_BYTES);
  localparam logic [31:0]      HALF32 = 32'(PBA_OFS);
  localparam logic [BIR_W-1:0] BIR    = BIR_W'(BAR_IDX);

  logic [31:0] rounded;

  always_comb begin
    size_ok = (host_size <= MAX_HOST_BAR);
    if (host_size == '0)         rounded = '0;
    else if (host_size < PAGE32) rounded = PAGE32;
    else                         rounded = host_size;

    if (host_size == '0) new_size = {1'b0, PAGE32};
    else                 new_size = {rounded, 1'b0};

    table_ofs = rounded | {{(32-BIR_W){1'b0}}, BIR};
    pba_ofs   = (rounded + HALF32) | {{(32-BIR_W){1'b0}}, BIR};
  end
endmodule

// File: rtl/msix_ctrl_regs.sv
module msix_ctrl_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_wr,
  input  logic wr_en_bit,
  input  logic wr_mask_bit,
  output logic en_q,
  output logic mask_q,
  output logic intx_q,
  output logic rescan_q
);
  logic en_d, mask_d, intx_d, rescan_d;

  always_comb begin
    en_d     = en_q;
    mask_d   = mask_q;
    if (ctrl_wr) begin
      en_d   = wr_en_bit;
      mask_d = wr_mask_bit;
    end
    intx_d   = ctrl_wr & wr_en_bit;
    rescan_d = ctrl_wr & wr_en_bit & ~wr_mask_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mask_q <= 1'b0;
    end else if (ctrl_wr) begin
      en_q   <= en_d;
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      intx_q   <= 1'b0;
      rescan_q <= 1'b0;
    end else begin
      intx_q   <= intx_d;
      rescan_q <= rescan_d;
    end
  end

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable({en_q, mask_q})); // R6
  AST_INTX_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    intx_q |-> en_q); // R7
  AST_RESCAN_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    rescan_q |-> (en_q && !mask_q && intx_q)); // R8
  AST_PULSE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> (!intx_q && !rescan_q)); // R8
endmodule

// File: rtl/msix_cfg_rdmux.sv
module msix_cfg_rdmux
  import msix_cap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       dw [CAP_DWORDS],
  output logic [31:0]       rdata,
  output logic              rvalid
);
  logic [31:0] rdata_d;

  always_comb begin
    rdata_d = '0;
    for (int i = 0; i < CAP_DWORDS; i++) begin
      if (addr == ADDR_W'(i)) rdata_d = dw[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rvalid <= 1'b0;
    else         rvalid <= rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= rdata_d;
  end

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rvalid); // R9
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !rvalid); // R9
endmodule

// File: rtl/msix_cap_block.sv
module msix_cap_block
  import msix_cap_pkg::*;
#(
  parameter int         NUM_VEC  = 8,
  parameter int         BAR_IDX  = 2,
  parameter logic [7:0] NEXT_PTR = 8'h50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       host_bar_size,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              cfg_rvalid,
  output logic              cap_present,
  output logic [32:0]       bar_size,
  output logic              msix_enable,
  output logic              func_mask,
  output logic              intx_deassert,
  output logic              rescan_req
);
  localparam bit               VEC_OK = (NUM_VEC >= 1) && (NUM_VEC <= MAX_VEC);
  localparam logic [TSIZE_W-1:0] TSIZE = VEC_OK ? TSIZE_W'(NUM_VEC - 1) : '0;

  logic        rst_sync_n;
  logic        size_ok;
  logic [32:0] new_size;
  logic [31:0] table_ofs, pba_ofs;
  logic        ctrl_wr;
  logic        en_q, mask_q;
  logic [31:0] dw [CAP_DWORDS];
  logic        unused_bits;

  assign unused_bits = ^{cfg_wdata[MASK_BIT-1:0], cfg_be[2:0]};

  msix_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  msix_bar_calc #(.BAR_IDX(BAR_IDX)) u_bar (
    .host_size (host_bar_size),
    .size_ok   (size_ok),
    .new_size  (new_size),
    .table_ofs (table_ofs),
    .pba_ofs   (pba_ofs)
  );

  always_comb begin
    cap_present = VEC_OK && size_ok;
    bar_size    = cap_present ? new_size : {1'b0, host_bar_size};
    ctrl_wr     = cfg_wr && cap_present && (cfg_addr == '0) && cfg_be[3];
  end

  msix_ctrl_regs u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .ctrl_wr     (ctrl_wr),
    .wr_en_bit   (cfg_wdata[EN_BIT]),
    .wr_mask_bit (cfg_wdata[MASK_BIT]),
    .en_q        (en_q),
    .mask_q      (mask_q),
    .intx_q      (intx_deassert),
    .rescan_q    (rescan_req)
  );

  assign msix_enable = en_q & cap_present;
  assign func_mask   = mask_q & cap_present;

  always_comb begin
    if (cap_present) begin
      dw[0] = {en_q, mask_q, 3'b000, TSIZE, NEXT_PTR, CAP_ID};
      dw[1] = table_ofs;
      dw[2] = pba_ofs;
    end else begin
      for (int i = 0; i < CAP_DWORDS; i++) dw[i] = '0;
    end
  end

  msix_cfg_rdmux u_rd (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .rd     (cfg_rd),
    .addr   (cfg_addr),
    .dw     (dw),
    .rdata  (cfg_rdata),
    .rvalid (cfg_rvalid)
  );

  AST_ABSENT_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cap_present |=> !rescan_req); // R5
  AST_ABSENT_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_rd && !cap_present) |=> (cfg_rdata == '0)); // R5
endmodule

// File: tb/msix_cap_block_test.sv
module msix_cap_block_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] host_bar_size;
  logic        cfg_wr, cfg_rd;
  logic [1:0]  cfg_addr;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata, b_rdata;
  logic        cfg_rvalid, b_rvalid;
  logic        cap_present, b_present;
  logic [32:0] bar_size, b_bar;
  logic        msix_enable, func_mask, intx_deassert, rescan_req;
  logic        b_en, b_mask, b_intx, b_rescan;

  localparam int NV = 8;
  localparam int BI = 2;
  localparam logic [7:0] NP = 8'h50;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  msix_cap_block #(.NUM_VEC(NV), .BAR_IDX(BI), .NEXT_PTR(NP)) uut (
    .clk(clk), .rst_n(rst_n), .host_bar_size(host_bar_size),
    .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid),
    .cap_present(cap_present), .bar_size(bar_size), .msix_enable(msix_enable),
    .func_mask(func_mask), .intx_deassert(intx_deassert), .rescan_req(rescan_req));

  msix_cap_block #(.NUM_VEC(0), .BAR_IDX(BI), .NEXT_PTR(NP)) uut_bad (
    .clk(clk), .rst_n(rst_n), .host_bar_size(host_bar_size),
    .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(b_rdata), .cfg_rvalid(b_rvalid),
    .cap_present(b_present), .bar_size(b_bar), .msix_enable(b_en),
    .func_mask(b_mask), .intx_deassert(b_intx), .rescan_req(b_rescan));

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = 4'h0; cfg_wdata = '0;
  endtask

  task automatic do_read(input logic [1:0] a);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_addr = a;
    @(negedge clk);
    cfg_rd = 1'b0;
  endtask

  function automatic logic [31:0] exp_dw0(input logic en, input logic mk);
    return {en, mk, 3'b000, 11'(NV - 1), NP, 8'h11};
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] sizes [14];
    rst_n = 1'b0; cfg_wr = 0; cfg_rd = 0; cfg_addr = 0; cfg_be = 0; cfg_wdata = 0;
    host_bar_size = 32'h4000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 enable", msix_enable, 0);
    check("R1 mask", func_mask, 0);
    check("R1 intx", intx_deassert, 0);
    check("R1 rescan", rescan_req, 0);
    check("R1 rvalid", cfg_rvalid, 0);

    // R2 / R9 dword0 layout and read latency
    do_read(2'd0);
    check("R9 rvalid", cfg_rvalid, 1);
    check("R2 dword0", cfg_rdata, exp_dw0(0, 0));
    @(negedge clk);
    check("R9 rvalid drops", cfg_rvalid, 0);
    do_read(2'd3);
    check("R9 dword3 zero", cfg_rdata, 0);

    // R3 / R4 host BAR size sweep
    sizes = '{32'h0, 32'h1, 32'h7FF, 32'hFFF, 32'h1000, 32'h1001, 32'h2000,
              32'h10000, 32'h40000000, 32'h7FFFFFFF, 32'h80000000,
              32'h80000001, 32'hC0000000, 32'hFFFFFFFF};
    foreach (sizes[i]) begin
      logic [63:0] h, s, nb;
      logic        ok;
      h  = {32'h0, sizes[i]};
      ok = (h <= 64'h80000000);
      s  = (h == 0) ? 64'h0 : ((h < 64'h1000) ? 64'h1000 : h);
      nb = !ok ? h : ((h == 0) ? 64'h1000 : 2 * s);
      host_bar_size = sizes[i];
      @(negedge clk);
      check("R3 present", cap_present, ok);
      check("R3 bar size", bar_size, nb);
      do_read(2'd1);
      check("R4 table offset", cfg_rdata, ok ? ((s | BI) & 64'hFFFFFFFF) : 0);
      do_read(2'd2);
      check("R4 pba offset", cfg_rdata, ok ? (((s + 64'h800) | BI) & 64'hFFFFFFFF) : 0);
    end
    host_bar_size = 32'h4000;

    // R6 R7 R8 sweep of prior state x byte enables x written bits
    for (int p = 0; p < 4; p++) begin
      for (int be = 0; be < 16; be++) begin
        for (int v = 0; v < 4; v++) begin
          logic hit, en_e, mk_e;
          do_write(2'd0, 4'h8, {p[1], p[0], 30'h0});
          hit  = be[3];
          en_e = hit ? v[1] : p[1];
          mk_e = hit ? v[0] : p[0];
          do_write(2'd0, be[3:0], {v[1], v[0], 30'h3FFFFFFF});
          check("R6 enable", msix_enable, en_e);
          check("R6 mask", func_mask, mk_e);
          check("R7 intx pulse", intx_deassert, hit & v[1]);
          check("R8 rescan pulse", rescan_req, hit & v[1] & ~v[0]);
          @(negedge clk);
          check("R7 intx single", intx_deassert, 0);
          check("R8 rescan single", rescan_req, 0);
        end
      end
    end

    // R6 other dwords are read-only
    do_write(2'd0, 4'h8, 32'h8000_0000);
    do_write(2'd1, 4'hF, 32'hFFFF_FFFF);
    check("R8 no pulse off control", rescan_req, 0);
    do_write(2'd2, 4'hF, 32'hFFFF_FFFF);
    check("R6 enable kept", msix_enable, 1);
    do_read(2'd0);
    check("R6 dword0 after writes", cfg_rdata, exp_dw0(1, 0));
    do_read(2'd1);
    check("R6 table offset kept", cfg_rdata, 32'h4000 | BI);
    do_read(2'd2);
    check("R6 pba offset kept", cfg_rdata, 32'h4800 | BI);

    // R5 capability absent for a bad vector count
    check("R5 bad present", b_present, 0);
    check("R5 bad bar", b_bar, 33'h4000);
    do_write(2'd0, 4'hF, 32'h8000_0000);
    check("R5 bad enable", b_en, 0);
    check("R5 bad intx", b_intx, 0);
    check("R5 bad rescan", b_rescan, 0);
    do_read(2'd0);
    check("R5 bad read", b_rdata, 0);

    // R10 reset while running
    do_write(2'd0, 4'h8, 32'hC000_0000);
    check("R10 set before reset", {msix_enable, func_mask}, 2'b11);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 enable cleared", msix_enable, 0);
    check("R10 mask cleared", func_mask, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    do_read(2'd0);
    check("R10 dword0 after reset", cfg_rdata, exp_dw0(0, 0));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule